// File: doc/BRIEF.md
# Bus-Matching Width Converter

This stage sits in front of a byte-granular FIFO core and adapts the width of the data on each side. The write side and the read side are each either 18 bits or 9 bits wide, which gives four combinations. When the two widths differ, an 18-bit word is split into two 9-bit words, or two 9-bit words are joined into one 18-bit word. A byte-order setting decides which 9-bit half travels first. Both sides are valid/ready streams on a single clock.

The two width selects and the byte-order select are sampled on every clock edge while master reset is high. After that they are held, and the pins have no effect. In the equal-width modes the stage is a single register stage. In the splitting and joining modes it holds one 9-bit half in a side register.

Top module: `width_match_stage`

## Requirements
- R1: `cfgNarrowIn` selects the write width (0 = 18 bits, 1 = 9 bits) and `cfgNarrowOut` selects the read width (0 = 18 bits, 1 = 9 bits). The four combinations map as 0/0 = 18→18, 0/1 = 18→9, 1/0 = 9→18, 1/1 = 9→9.
- R2: `cfgNarrowIn`, `cfgNarrowOut` and `cfgBigEnd` are captured at rising clock edges while `rst` is 1. Changing them while `rst` is 0 does not change the output stream.
- R3: In both equal-width modes a word accepted at a clock edge appears unchanged on `outData`, with `outValid` high, immediately after that edge, and words leave in the order they arrived.
- R4: With a 9-bit write side, `inData[17:9]` is ignored. With a 9-bit read side, `outData[17:9]` reads 0 whenever `outValid` is 1, and the data sits in `outData[8:0]`.
- R5: In 18→9 mode with `cfgBigEnd`=1, `inData[17:9]` is delivered first and `inData[8:0]` second.
- R6: In 18→9 mode with `cfgBigEnd`=0, `inData[8:0]` is delivered first and `inData[17:9]` second.
- R7: In 18→9 mode `inReady` is 0 in the cycle after an 18-bit word is accepted, and it stays 0 until the second half has been handed to the read side.
- R8: In 9→18 mode the first 9-bit word of a pair becomes `outData[17:9]` when `cfgBigEnd`=1, or `outData[8:0]` when `cfgBigEnd`=0. `outValid` rises only after both words of the pair have been accepted.
- R9: While `outValid` is 1 and `outReady` is 0, `outValid` stays 1 and `outData` stays unchanged on the next cycle.
- R10: Right after reset, `outValid` is 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high; configuration is sampled while it is high |
| cfgNarrowIn | input | 1 | Write width select, 1 = 9 bits |
| cfgNarrowOut | input | 1 | Read width select, 1 = 9 bits |
| cfgBigEnd | input | 1 | Byte order, 1 = upper half first |
| inValid | input | 1 | Write-side word valid |
| inReady | output | 1 | Write side can accept |
| inData | input | 18 | Write-side word (bits 8:0 only in 9-bit mode) |
| outValid | output | 1 | Read-side word valid |
| outReady | input | 1 | Read side takes the word |
| outData | output | 18 | Read-side word (bits 8:0 only in 9-bit mode) |

## Verification
The hardest case to reach is a pending half meeting backpressure on both sides at once. In 18→9 mode this is a second half waiting while the reader stalls and the writer keeps offering. In 9→18 mode it is a completed word stuck on the output while the next first half is already held. Each of the eight reset configurations is driven with long streams in which `inValid` and `outReady` are drawn at random every cycle, so these overlaps happen many times. The configuration pins are scrambled after reset and the upper input bits carry noise in narrow modes. The bench derives the expected order of halves arithmetically from each written word and tracks the expected `outValid` occupancy cycle by cycle.

// File: rtl/wm_pkg.sv
package wm_pkg;
  typedef enum logic [1:0] {
    MODE_PASS,
    MODE_SPLIT,
    MODE_JOIN
  } mode_e;

  typedef enum logic [1:0] {
    SEL_PASS,
    SEL_FIRST,
    SEL_HOLD,
    SEL_JOIN
  } outSel_e;

  typedef struct packed {
    logic    outLoad;
    outSel_e outSel;
    logic    holdLoad;
  } strobe_t;
endpackage

// File: rtl/wm_ctrl.sv
module wm_ctrl
  import wm_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cfgNarrowIn,
  input  logic    cfgNarrowOut,
  input  logic    cfgBigEnd,
  input  logic    inValid,
  input  logic    outReady,
  output logic    inReady,
  output logic    outValid,
  output strobe_t stb,
  output logic    narrowIn,
  output logic    narrowOut,
  output logic    bigEnd,
  output mode_e   mode
);
  logic holdValidQ, holdValidN;
  logic outValidQ, outValidN;
  logic outFree, outFire, inFire;

  always_ff @(posedge clk) begin
    if (rst) begin
      narrowIn   <= cfgNarrowIn;
      narrowOut  <= cfgNarrowOut;
      bigEnd     <= cfgBigEnd;
      holdValidQ <= 1'b0;
      outValidQ  <= 1'b0;
    end else begin
      holdValidQ <= holdValidN;
      outValidQ  <= outValidN;
    end
  end

  always_comb begin
    if (narrowIn == narrowOut) mode = MODE_PASS;
    else if (narrowOut)        mode = MODE_SPLIT;
    else                       mode = MODE_JOIN;
  end

  assign outFree  = !outValidQ || outReady;
  assign outFire  = outValidQ && outReady;
  assign outValid = outValidQ;
  assign inFire   = inValid && inReady;

  always_comb begin
    stb        = '0;
    holdValidN = holdValidQ;
    outValidN  = outValidQ && !outFire;
    inReady    = 1'b0;
    unique case (mode)
      MODE_SPLIT: begin
        inReady = !holdValidQ && outFree;
        if (holdValidQ && outFree) begin
          stb.outLoad = 1'b1;
          stb.outSel  = SEL_HOLD;
          holdValidN  = 1'b0;
          outValidN   = 1'b1;
        end else if (inFire) begin
          stb.outLoad  = 1'b1;
          stb.outSel   = SEL_FIRST;
          stb.holdLoad = 1'b1;
          holdValidN   = 1'b1;
          outValidN    = 1'b1;
        end
      end
      MODE_JOIN: begin
        inReady = !holdValidQ || outFree;
        if (inFire) begin
          if (!holdValidQ) begin
            stb.holdLoad = 1'b1;
            holdValidN   = 1'b1;
          end else begin
            stb.outLoad = 1'b1;
            stb.outSel  = SEL_JOIN;
            holdValidN  = 1'b0;
            outValidN   = 1'b1;
          end
        end
      end
      default: begin
        inReady = outFree;
        if (inFire) begin
          stb.outLoad = 1'b1;
          stb.outSel  = SEL_PASS;
          outValidN   = 1'b1;
        end
      end
    endcase
  end

  // R7: a wide word just taken leaves a half behind, so the writer must wait
  assert_split_blocks_writer_R7: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SPLIT && inValid && inReady) |=> !inReady);

  // R8: with nothing held and nothing shown, one narrow word cannot make output
  assert_join_needs_pair_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_JOIN && !holdValidQ && !outValidQ) |=> !outValid);
endmodule

// File: rtl/wm_datapath.sv
module wm_datapath
  import wm_pkg::*;
#(
  parameter int HALF_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             stb,
  input  logic                narrowIn,
  input  logic                bigEnd,
  input  logic [2*HALF_W-1:0] inData,
  output logic [2*HALF_W-1:0] outData
);
  localparam int FULL_W = 2 * HALF_W;

  logic [HALF_W-1:0] inHi, inLo, firstHalf, secondHalf, holdReg, holdNext;
  logic [FULL_W-1:0] outReg, outNext;

  assign inHi       = inData[FULL_W-1:HALF_W];
  assign inLo       = inData[HALF_W-1:0];
  assign firstHalf  = bigEnd ? inHi : inLo;
  assign secondHalf = bigEnd ? inLo : inHi;
  assign holdNext   = narrowIn ? inLo : secondHalf;

  always_comb begin
    unique case (stb.outSel)
      SEL_FIRST: outNext = {{HALF_W{1'b0}}, firstHalf};
      SEL_HOLD:  outNext = {{HALF_W{1'b0}}, holdReg};
      SEL_JOIN:  outNext = bigEnd ? {holdReg, inLo} : {inLo, holdReg};
      default:   outNext = narrowIn ? {{HALF_W{1'b0}}, inLo} : inData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg <= '0;
      outReg  <= '0;
    end else begin
      if (stb.holdLoad) holdReg <= holdNext;
      if (stb.outLoad)  outReg  <= outNext;
    end
  end

  assign outData = outReg;
endmodule

// File: rtl/width_match_stage.sv
module width_match_stage
  import wm_pkg::*;
#(
  parameter int HALF_W = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfgNarrowIn,
  input  logic                cfgNarrowOut,
  input  logic                cfgBigEnd,
  input  logic                inValid,
  output logic                inReady,
  input  logic [2*HALF_W-1:0] inData,
  output logic                outValid,
  input  logic                outReady,
  output logic [2*HALF_W-1:0] outData
);
  localparam int FULL_W = 2 * HALF_W;

  strobe_t stb;
  logic    narrowIn, narrowOut, bigEnd;
  mode_e   mode;

  wm_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .cfgNarrowIn(cfgNarrowIn), .cfgNarrowOut(cfgNarrowOut), .cfgBigEnd(cfgBigEnd),
    .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .stb(stb),
    .narrowIn(narrowIn), .narrowOut(narrowOut), .bigEnd(bigEnd), .mode(mode)
  );

  wm_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb),
    .narrowIn(narrowIn), .bigEnd(bigEnd),
    .inData(inData), .outData(outData)
  );

  // R9: a refused word is held in place
  assert_out_held_R9: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R4: a narrow read side never shows upper bits
  assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (narrowOut && outValid) |-> (outData[FULL_W-1:HALF_W] == '0));

  // R3: equal widths give one register of latency and no change to the word
  assert_pass_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PASS && inValid && inReady) |=>
      (outValid && outData == ($past(narrowIn) ? {{HALF_W{1'b0}}, $past(inData[HALF_W-1:0])}
                                                : $past(inData))));
endmodule

// File: tb/width_match_stage_tb.sv
module width_match_stage_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_W = 9;
  localparam int FULL_W = 2 * HALF_W;
  localparam int NWORDS = 48;
  localparam int CYC_LIMIT = 4000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfgNarrowIn = 1'b0, cfgNarrowOut = 1'b0, cfgBigEnd = 1'b0;
  logic inValid = 1'b0, outReady = 1'b0;
  logic [FULL_W-1:0] inData = '0;
  logic inReady, outValid;
  logic [FULL_W-1:0] outData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [FULL_W-1:0] inWords [NWORDS];
  logic [FULL_W-1:0] expWords [2*NWORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  width_match_stage #(.HALF_W(HALF_W)) u_dut (
    .clk(clk), .rst(rst),
    .cfgNarrowIn(cfgNarrowIn), .cfgNarrowOut(cfgNarrowOut), .cfgBigEnd(cfgBigEnd),
    .inValid(inValid), .inReady(inReady), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  task automatic check(input bit ok, input string req, input logic [FULL_W-1:0] act,
                       input logic [FULL_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    for (int cfg = 0; cfg < 8; cfg++) begin
      bit ni, no, be, split, join_, fire, prevFire, stallPend;
      int nOut, inIdx, outIdx, cyc, produced;
      logic [FULL_W-1:0] stallData, w;
      string tag;
      ni = cfg[2]; no = cfg[1]; be = cfg[0];
      split = !ni && no;
      join_ = ni && !no;

      // expected stream, from R1, R4, R5, R6, R8
      for (int i = 0; i < NWORDS; i++) inWords[i] = FULL_W'($urandom);
      if (split) begin
        nOut = 2 * NWORDS;
        for (int i = 0; i < NWORDS; i++) begin
          w = inWords[i];
          expWords[2*i]   = {9'b0, be ? w[17:9] : w[8:0]};
          expWords[2*i+1] = {9'b0, be ? w[8:0] : w[17:9]};
        end
        tag = be ? "R1 R5" : "R1 R6";
      end else if (join_) begin
        nOut = NWORDS / 2;
        for (int i = 0; i < NWORDS / 2; i++)
          expWords[i] = be ? {inWords[2*i][8:0], inWords[2*i+1][8:0]}
                           : {inWords[2*i+1][8:0], inWords[2*i][8:0]};
        tag = "R1 R8 R4";
      end else begin
        nOut = NWORDS;
        for (int i = 0; i < NWORDS; i++)
          expWords[i] = ni ? {9'b0, inWords[i][8:0]} : inWords[i];
        tag = ni ? "R1 R3 R4" : "R1 R3";
      end

      // reset with this configuration (R2 capture)
      @(negedge clk);
      rst = 1'b1;
      cfgNarrowIn = ni; cfgNarrowOut = no; cfgBigEnd = be;
      inValid = 1'b0; outReady = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      check(outValid == 1'b0, "R10 outValid after reset", {17'b0, outValid}, '0);
      check(inReady == 1'b1, "R10 inReady after reset", {17'b0, inReady}, 18'd1);

      inIdx = 0; outIdx = 0; cyc = 0; prevFire = 0; stallPend = 0; stallData = '0;
      while (outIdx < nOut && cyc < CYC_LIMIT) begin
        // R2: scramble configuration pins after reset
        cfgNarrowIn = 1'($urandom); cfgNarrowOut = 1'($urandom); cfgBigEnd = 1'($urandom);
        if (!inValid && inIdx < NWORDS && ($urandom % 4 != 0)) begin
          inValid = 1'b1;
          inData = ni ? {9'($urandom), inWords[inIdx][8:0]} : inWords[inIdx];
        end
        outReady = ($urandom % 3 != 0);
        #1;

        produced = split ? 2 * inIdx : (join_ ? inIdx / 2 : inIdx);
        check(outValid == (produced != outIdx),
              split ? "R7 occupancy" : (join_ ? "R8 occupancy" : "R3 occupancy"),
              {17'b0, outValid}, {17'b0, produced != outIdx});
        if (stallPend)
          check(outValid && outData == stallData, "R9 held word", outData, stallData);
        if (split && prevFire)
          check(inReady == 1'b0, "R7 inReady after wide accept", {17'b0, inReady}, '0);
        if (outValid && outReady) begin
          check(outData == expWords[outIdx], {tag, " R2 data"}, outData, expWords[outIdx]);
          outIdx++;
        end
        stallPend = outValid && !outReady;
        stallData = outData;
        fire = inValid && inReady;
        if (fire) inIdx++;
        prevFire = fire;
        @(negedge clk);
        if (fire) inValid = 1'b0;
        cyc++;
      end
      if (cyc >= CYC_LIMIT) begin
        checks++;
        fails++;
        $display("FAIL watchdog cfg=%0d actual=%0d expected=%0d words", cfg, outIdx, nOut);
      end
      inValid = 1'b0;
      outReady = 1'b0;
    end
    done = 1'b1;
    summary();
  end
endmodule